// File: doc/BRIEF.md
# Preemption Verify and Respond Controller

This block is the control core of a frame-preemption merge layer. Before a link starts sending preemptible traffic, the local side sends verify mPackets to the partner. It waits a programmable time for a response mPacket and tries up to a fixed number of times. It then declares the link either verified or failed. While that runs, a second, independent machine answers the partner's own verify mPackets by asking the transmitter to send a response.

The block drives request lines toward the transmit path and takes a done pulse back for each one. It reports both machines' states as encoded fields and produces a preemption-active output. That output is true after a successful verification, or at once when verification is switched off and preemption is enabled. Malformed received verify or response mPackets each set a sticky flag, which a status-read strobe clears. Forming the mPackets and the transmit datapath lie outside the block.

Top module: `preempt_verify_ctrl`

## Requirements
- R1: While reset is asserted and after it, before any stimulus, every output is 0: verifyState=0, respondState=0, preemptActive=0, both error flags 0, both transmit requests 0.
- R2: verifyState uses the codes INIT=0, IDLE=1, SEND_VERIFY=2, WAIT_FOR_RESPONSE=3, VERIFIED=4, VERIFY_FAIL=5. With enableIn and linkUpIn both 1, INIT moves to IDLE on the next clock. IDLE moves to SEND_VERIFY on a clock where preemptEnableIn=1 and verifyDisableIn=0.
- R3: txVerifyReq is 1 exactly while verifyState is SEND_VERIFY. A txVerifyDone pulse in that state moves the machine to WAIT_FOR_RESPONSE on the next clock.
- R4: In WAIT_FOR_RESPONSE, a clock with rxRespValid=1 and rxRespOk=1 moves the machine to VERIFIED. This takes priority over a timeout in the same cycle.
- R5: With no good response, WAIT_FOR_RESPONSE lasts exactly max(timeoutCycles,1) cycles. It then returns to SEND_VERIFY if fewer than MAX_ATTEMPTS verifies have been sent.
- R6: When the wait after the MAX_ATTEMPTS-th verify (3 by default) expires, the machine enters VERIFY_FAIL and stays there while enabled and linked.
- R7: A clock with enableIn=0 or linkUpIn=0 puts verifyState to INIT and respondState to R_IDLE, whatever their prior state.
- R8: preemptActive equals enableIn & linkUpIn & preemptEnableIn & (verifyState==VERIFIED | verifyDisableIn), combinationally.
- R9: respondState uses R_IDLE=0 and SEND_RESPOND=1, and txRespReq equals it. A clock with rxVerifyValid=1, rxVerifyOk=1 while enabled and linked moves R_IDLE to SEND_RESPOND. txRespDone moves it back on the next clock.
- R10: verifyErr becomes 1 on the clock after rxVerifyValid=1 with rxVerifyOk=0. It returns to 0 on the clock after statusRead=1, unless a new malformed verify arrives in that same cycle.
- R11: respErr behaves like verifyErr, for rxRespValid=1 with rxRespOk=0. A malformed response does not move WAIT_FOR_RESPONSE to VERIFIED.
- R12: A good response received in any state other than WAIT_FOR_RESPONSE leaves verifyState unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enableIn | input | 1 | Merge layer enable |
| linkUpIn | input | 1 | Link status |
| preemptEnableIn | input | 1 | Preemption wanted |
| verifyDisableIn | input | 1 | Skip verification |
| timeoutCycles | input | TIMER_W | Response wait length in cycles (0 treated as 1) |
| rxVerifyValid | input | 1 | A verify mPacket was received this cycle |
| rxVerifyOk | input | 1 | That verify mPacket is well formed |
| rxRespValid | input | 1 | A response mPacket was received this cycle |
| rxRespOk | input | 1 | That response mPacket is well formed |
| txVerifyDone | input | 1 | Transmitter finished the verify mPacket |
| txRespDone | input | 1 | Transmitter finished the response mPacket |
| statusRead | input | 1 | Status read strobe, clears error flags |
| txVerifyReq | output | 1 | Request to send a verify mPacket |
| txRespReq | output | 1 | Request to send a response mPacket |
| verifyState | output | 3 | Encoded verify machine state |
| respondState | output | 1 | Encoded responder state |
| preemptActive | output | 1 | Preemption active |
| verifyErr | output | 1 | Sticky malformed-verify flag |
| respErr | output | 1 | Sticky malformed-response flag |

## Verification
The bench builds the block with TIMER_W=6 and the default MAX_ATTEMPTS=3. This keeps every wait short, so the full retry path into VERIFY_FAIL is reached many times within a run. Directed runs use timeoutCycles=3. The random phase changes it among 0 to 4, which reaches the zero-is-one corner and the one-cycle wait in which a response and a timeout coincide.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic [2:0] {
    VS_INIT = 3'd0,
    VS_IDLE = 3'd1,
    VS_SEND = 3'd2,
    VS_WAIT = 3'd3,
    VS_DONE = 3'd4,
    VS_FAIL = 3'd5
  } vstate_e;

  typedef enum logic {
    RS_IDLE = 1'b0,
    RS_SEND = 1'b1
  } rstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAttempt;
    logic incAttempt;
    logic clrTimer;
    logic runTimer;
  } dpCmd_t;
endpackage

// File: rtl/pv_datapath.sv
module pv_datapath
  import pv_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int MAX_ATTEMPTS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [TIMER_W-1:0] timeoutCycles,
  input  logic               rxVerifyValid,
  input  logic               rxVerifyOk,
  input  logic               rxRespValid,
  input  logic               rxRespOk,
  input  logic               statusRead,
  output logic               timeoutHit,
  output logic               lastAttempt,
  output logic               verifyErr,
  output logic               respErr
);
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int CMP_W = TIMER_W + 1;
  localparam int N_FLAGS = 2;

  logic [TIMER_W-1:0] timer;
  logic [CMP_W-1:0]   limitVal;
  logic [ATT_W-1:0]   attempts;

  assign limitVal   = (timeoutCycles == '0) ? CMP_W'(1) : {1'b0, timeoutCycles};
  assign timeoutHit = ({1'b0, timer} + CMP_W'(1)) >= limitVal;
  assign lastAttempt = attempts >= ATT_W'(MAX_ATTEMPTS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (cmd.clrTimer) timer <= '0;
    else if (cmd.runTimer && !timeoutHit) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) attempts <= '0;
    else if (cmd.clrAttempt) attempts <= '0;
    else if (cmd.incAttempt && !lastAttempt) attempts <= attempts + 1'b1;
  end

  // sticky error flags, a new event wins over a read clear
  logic [N_FLAGS-1:0] errEvent;
  logic [N_FLAGS-1:0] errFlag;
  assign errEvent = {rxRespValid & ~rxRespOk, rxVerifyValid & ~rxVerifyOk};

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errFlag[i] <= 1'b0;
      else errFlag[i] <= errEvent[i] | (errFlag[i] & ~statusRead);
    end
  end

  assign verifyErr = errFlag[0];
  assign respErr   = errFlag[1];

  // R10: malformed verify raises the flag
  a_r10_verify_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (rxVerifyValid && !rxVerifyOk) |=> verifyErr);
  // R10: read without new event clears
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(rxVerifyValid && !rxVerifyOk)) |=> !verifyErr);
  // R11: malformed response raises the flag
  a_r11_resp_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (rxRespValid && !rxRespOk) |=> respErr);
endmodule

// File: rtl/pv_control.sv
module pv_control
  import pv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableIn,
  input  logic       linkUpIn,
  input  logic       preemptEnableIn,
  input  logic       verifyDisableIn,
  input  logic       rxVerifyValid,
  input  logic       rxVerifyOk,
  input  logic       rxRespValid,
  input  logic       rxRespOk,
  input  logic       txVerifyDone,
  input  logic       txRespDone,
  input  logic       timeoutHit,
  input  logic       lastAttempt,
  output dpCmd_t     cmd,
  output logic [2:0] verifyState,
  output logic       respondState,
  output logic       txVerifyReq,
  output logic       txRespReq,
  output logic       preemptActive
);
  vstate_e vState, vNext;
  rstate_e rState, rNext;
  logic    linkOk;
  logic    respHit;

  assign linkOk  = enableIn && linkUpIn;
  assign respHit = rxRespValid && rxRespOk;

  always_comb begin
    vNext = vState;
    cmd   = '0;
    if (!linkOk) begin
      vNext = VS_INIT;
    end else begin
      unique case (vState)
        VS_INIT: begin
          cmd.clrAttempt = 1'b1;
          vNext = VS_IDLE;
        end
        VS_IDLE: begin
          cmd.clrAttempt = 1'b1;
          if (preemptEnableIn && !verifyDisableIn) vNext = VS_SEND;
        end
        VS_SEND: begin
          cmd.clrTimer = 1'b1;
          if (txVerifyDone) begin
            cmd.incAttempt = 1'b1;
            vNext = VS_WAIT;
          end
        end
        VS_WAIT: begin
          cmd.runTimer = 1'b1;
          if (respHit) vNext = VS_DONE;
          else if (timeoutHit) vNext = lastAttempt ? VS_FAIL : VS_SEND;
        end
        default: vNext = vState;
      endcase
    end
  end

  always_comb begin
    rNext = rState;
    if (!linkOk) rNext = RS_IDLE;
    else if (rState == RS_IDLE && rxVerifyValid && rxVerifyOk) rNext = RS_SEND;
    else if (rState == RS_SEND && txRespDone) rNext = RS_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vState <= VS_INIT;
      rState <= RS_IDLE;
    end else begin
      vState <= vNext;
      rState <= rNext;
    end
  end

  assign verifyState   = vState;
  assign respondState  = rState;
  assign txVerifyReq   = (vState == VS_SEND);
  assign txRespReq     = (rState == RS_SEND);
  assign preemptActive = linkOk && preemptEnableIn &&
                         ((vState == VS_DONE) || verifyDisableIn);

  // R7: dropping link or enable returns both machines to rest
  a_r7_drop_to_init: assert property (@(posedge clk) disable iff (!rstN)
    (!enableIn || !linkUpIn) |=> (verifyState == 3'd0 && !respondState));
  // R4: verified is only reached from the waiting state
  a_r4_done_from_wait: assert property (@(posedge clk) disable iff (!rstN)
    (vState != VS_DONE && vNext == VS_DONE) |-> (vState == VS_WAIT && respHit));
  // R6: failure only after the final attempt
  a_r6_fail_needs_last: assert property (@(posedge clk) disable iff (!rstN)
    (vState == VS_FAIL) |-> lastAttempt);
  // R9: responder releases after done
  a_r9_resp_release: assert property (@(posedge clk) disable iff (!rstN)
    (respondState && txRespDone) |=> !respondState);
endmodule

// File: rtl/preempt_verify_ctrl.sv
module preempt_verify_ctrl
  import pv_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int MAX_ATTEMPTS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enableIn,
  input  logic               linkUpIn,
  input  logic               preemptEnableIn,
  input  logic               verifyDisableIn,
  input  logic [TIMER_W-1:0] timeoutCycles,
  input  logic               rxVerifyValid,
  input  logic               rxVerifyOk,
  input  logic               rxRespValid,
  input  logic               rxRespOk,
  input  logic               txVerifyDone,
  input  logic               txRespDone,
  input  logic               statusRead,
  output logic               txVerifyReq,
  output logic               txRespReq,
  output logic [2:0]         verifyState,
  output logic               respondState,
  output logic               preemptActive,
  output logic               verifyErr,
  output logic               respErr
);
  dpCmd_t cmd;
  logic   timeoutHit;
  logic   lastAttempt;

  pv_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .enableIn(enableIn), .linkUpIn(linkUpIn),
    .preemptEnableIn(preemptEnableIn), .verifyDisableIn(verifyDisableIn),
    .rxVerifyValid(rxVerifyValid), .rxVerifyOk(rxVerifyOk),
    .rxRespValid(rxRespValid), .rxRespOk(rxRespOk),
    .txVerifyDone(txVerifyDone), .txRespDone(txRespDone),
    .timeoutHit(timeoutHit), .lastAttempt(lastAttempt),
    .cmd(cmd), .verifyState(verifyState), .respondState(respondState),
    .txVerifyReq(txVerifyReq), .txRespReq(txRespReq),
    .preemptActive(preemptActive)
  );

  pv_datapath #(.TIMER_W(TIMER_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .timeoutCycles(timeoutCycles),
    .rxVerifyValid(rxVerifyValid), .rxVerifyOk(rxVerifyOk),
    .rxRespValid(rxRespValid), .rxRespOk(rxRespOk),
    .statusRead(statusRead),
    .timeoutHit(timeoutHit), .lastAttempt(lastAttempt),
    .verifyErr(verifyErr), .respErr(respErr)
  );
endmodule

// File: tb/preempt_verify_ctrl_tb_top.sv
module preempt_verify_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;
  localparam int MAXA = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableIn = 0, linkUpIn = 0, preemptEnableIn = 0, verifyDisableIn = 0;
  logic [TW-1:0] timeoutCycles = TW'(3);
  logic rxVerifyValid = 0, rxVerifyOk = 0, rxRespValid = 0, rxRespOk = 0;
  logic txVerifyDone = 0, txRespDone = 0, statusRead = 0;
  logic txVerifyReq, txRespReq, respondState, preemptActive, verifyErr, respErr;
  logic [2:0] verifyState;

  int nChecks = 0;
  int nBad = 0;
  bit cmpOn = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preempt_verify_ctrl #(.TIMER_W(TW), .MAX_ATTEMPTS(MAXA)) dut_i (.*);

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, built from the requirements
  int mV, mR, mAtt, mWait, mVerr, mRerr;

  function automatic int waitLimit(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int expPreempt(int v);
    return (enableIn && linkUpIn && preemptEnableIn && (v == 4 || verifyDisableIn)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mV = 0; mR = 0; mAtt = 0; mWait = 0; mVerr = 0; mRerr = 0;
    end else begin
      mVerr = (rxVerifyValid && !rxVerifyOk) ? 1 : (statusRead ? 0 : mVerr);
      mRerr = (rxRespValid && !rxRespOk) ? 1 : (statusRead ? 0 : mRerr);
      if (!(enableIn && linkUpIn)) begin
        mV = 0; mR = 0;
      end else begin
        case (mV)
          0: begin mAtt = 0; mV = 1; end
          1: begin mAtt = 0; if (preemptEnableIn && !verifyDisableIn) mV = 2; end
          2: begin mWait = 0; if (txVerifyDone) begin mAtt++; mV = 3; end end
          3: begin
            if (rxRespValid && rxRespOk) mV = 4;
            else if (mWait + 1 >= waitLimit(int'(timeoutCycles))) mV = (mAtt >= MAXA) ? 5 : 2;
            else mWait++;
          end
          default: ;
        endcase
        if (mR == 0 && rxVerifyValid && rxVerifyOk) mR = 1;
        else if (mR == 1 && txRespDone) mR = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn && !finished) begin
      check("R2 verifyState", int'(verifyState), mV);
      check("R3 txVerifyReq", int'(txVerifyReq), (mV == 2) ? 1 : 0);
      check("R8 preemptActive", int'(preemptActive), expPreempt(mV));
      check("R9 respondState", int'(respondState), mR);
      check("R9 txRespReq", int'(txRespReq), mR);
      check("R10 verifyErr", int'(verifyErr), mVerr);
      check("R11 respErr", int'(respErr), mRerr);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clearPulses();
    rxVerifyValid = 0; rxRespValid = 0; txVerifyDone = 0; txRespDone = 0; statusRead = 0;
  endtask

  task automatic waitFor(int s);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (int'(verifyState) == s) return;
    end
    check("R2 reach state", int'(verifyState), s);
  endtask

  // one verify send and its wait; returns cycles spent waiting
  task automatic sendAndWait(output int n);
    step(); txVerifyDone = 1;
    step(); txVerifyDone = 0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (int'(verifyState) == 3) n++;
      else break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 verifyState", int'(verifyState), 0);
    check("R1 respondState", int'(respondState), 0);
    check("R1 preemptActive", int'(preemptActive), 0);
    check("R1 errFlags", int'({verifyErr, respErr}), 0);
    check("R1 txReqs", int'({txVerifyReq, txRespReq}), 0);
    step(); rstN = 1;
    step(); cmpOn = 1;

    // retries into failure (R5, R6)
    enableIn = 1; linkUpIn = 1; preemptEnableIn = 1; timeoutCycles = TW'(3);
    waitFor(2);
    for (int a = 1; a <= MAXA; a++) begin
      sendAndWait(n);
      check("R5 wait length", n, 3);
      check(a < MAXA ? "R5 retry" : "R6 fail", int'(verifyState), a < MAXA ? 2 : 5);
    end
    repeat (5) step();
    @(negedge clk);
    check("R6 fail held", int'(verifyState), 5);
    check("R6 no preempt", int'(preemptActive), 0);

    // R7 link drop
    step(); linkUpIn = 0;
    @(negedge clk); @(negedge clk);
    check("R7 init", int'(verifyState), 0);

    // R11 malformed response, then R4 success
    step(); linkUpIn = 1;
    waitFor(2);
    step(); txVerifyDone = 1;
    step(); txVerifyDone = 0; rxRespValid = 1; rxRespOk = 0;
    step(); clearPulses();
    @(negedge clk);
    check("R11 stays waiting", int'(verifyState), 3);
    check("R11 flag", int'(respErr), 1);
    rxRespValid = 1; rxRespOk = 1;
    step(); clearPulses();
    @(negedge clk);
    check("R4 verified", int'(verifyState), 4);
    check("R8 active", int'(preemptActive), 1);
    // R12 stray response
    step(); rxRespValid = 1; rxRespOk = 1;
    step(); clearPulses(); statusRead = 1;
    step(); clearPulses();
    @(negedge clk);
    check("R12 unchanged", int'(verifyState), 4);
    check("R11 cleared", int'(respErr), 0);

    // R8 override, R9 responder, R10 flag
    step(); enableIn = 0;
    step(); enableIn = 1; verifyDisableIn = 1;
    repeat (3) step();
    @(negedge clk);
    check("R8 override idle", int'(verifyState), 1);
    check("R8 override active", int'(preemptActive), 1);
    step(); rxVerifyValid = 1; rxVerifyOk = 1;
    step(); clearPulses();
    @(negedge clk);
    check("R9 respond", int'(txRespReq), 1);
    step(); txRespDone = 1;
    step(); clearPulses(); rxVerifyValid = 1; rxVerifyOk = 0;
    step(); clearPulses();
    @(negedge clk);
    check("R9 released", int'(respondState), 0);
    check("R10 flag", int'(verifyErr), 1);
    verifyDisableIn = 0;

    // random phase, checked against the model every cycle
    for (int c = 0; c < 6000; c++) begin
      step();
      if (c % 400 == 0) timeoutCycles = TW'($urandom % 5);
      enableIn        = ($urandom % 100) < 98;
      linkUpIn        = ($urandom % 100) < 98;
      preemptEnableIn = ($urandom % 100) < 90;
      verifyDisableIn = ($urandom % 100) < 15;
      rxVerifyValid   = ($urandom % 100) < 8;
      rxVerifyOk      = ($urandom % 100) < 80;
      rxRespValid     = ($urandom % 100) < 10;
      rxRespOk        = ($urandom % 100) < 80;
      txVerifyDone    = ($urandom % 100) < 30;
      txRespDone      = ($urandom % 100) < 30;
      statusRead      = ($urandom % 100) < 10;
    end
    step(); clearPulses();
    repeat (2) step();
    summary();
  end
endmodule